// File: doc/BRIEF.md
# UART FIFO Status Flag Unit

This block derives the FIFO-related status flags and the combined interrupt request of a UART that has separate transmit and receive FIFOs plus one receive holding register in front of software. It does not store data. It watches the FIFO occupancy counts, the push and flush strobes, the programmed threshold codes, the transmit and receive enables, the wakeup event lines and the software clear strobe. From these it produces registered flags.

The threshold flags compare free transmit slots and filled receive slots against a fraction of the FIFO depth chosen by a 3-bit code. The receive-full flag treats the holding register as one extra slot. The transmit-empty flag follows the FIFO and can also be forced high by a flush request. The enable-acknowledge flags repeat each enable only after it has crossed a short synchronizer chain. The wakeup flag latches a selected event until software clears it. Every flag except the acknowledges can raise the interrupt through its own mask bit.

Top module: `uart_fifo_flags`

## Requirements
- R1: While reset is high, and on the first sample after it is released, every flag and `irq_o` are 0, except `tx_empty_flag_o`, which is 1.
- R2: One clock after the inputs are sampled, `tx_thr_flag_o` is 1 exactly when DEPTH minus `tx_level_i` is at least the code's threshold. Code 0 selects DEPTH/8, 1 selects DEPTH/4, 2 selects DEPTH/2, 3 selects 3·DEPTH/4, 4 selects 7·DEPTH/8 and 5 selects DEPTH.
- R3: One clock after sampling, `rx_thr_flag_o` is 1 exactly when `rx_level_i` is at least the threshold of `rx_thr_code_i`, using the same code table as R2.
- R4: Threshold codes 6 and 7 are reserved. A threshold flag whose code is reserved is 0 one clock later, whatever the level.
- R5: One clock after sampling, `rx_full_flag_o` is 1 exactly when `rx_level_i` equals DEPTH and `rx_hold_full_i` is 1.
- R6: `tx_empty_flag_o` falls one clock after a `tx_push_i` pulse that has no flush beside it. It rises one clock after `tx_level_i` is 0 without a push. Otherwise it holds its value.
- R7: A `tx_flush_req_i` pulse sets `tx_empty_flag_o` one clock later, even when a push arrives in the same cycle. The flag then stays high until the next push.
- R8: `tx_en_ack_o` and `rx_en_ack_o` take the value of `tx_en_i` and `rx_en_i` two clocks after the enable changes. The value is unchanged one clock after the change.
- R9: While `wake_en_i` is 1, a high on `wake_evt_i[wake_sel_i]` sets `wake_flag_o` one clock later. Events on lines that are not selected have no effect. A `wake_clr_i` pulse clears the flag, and when a set and a clear arrive in the same cycle the set wins.
- R10: While `wake_en_i` is 0, `wake_flag_o` is 0 one clock later and no event can set it.
- R11: `irq_o` is a register that holds the OR of the flags ANDed with `irq_mask_i`, one clock behind the flags. The mask bits are: 0 transmit threshold, 1 receive threshold, 2 receive full, 3 transmit empty, 4 wakeup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level_i | input | LW | Entries held in the transmit FIFO |
| rx_level_i | input | LW | Entries held in the receive FIFO |
| rx_hold_full_i | input | 1 | Receive holding register occupied |
| tx_thr_code_i | input | 3 | Transmit threshold code |
| rx_thr_code_i | input | 3 | Receive threshold code |
| tx_push_i | input | 1 | Transmit FIFO write strobe |
| tx_flush_req_i | input | 1 | Software transmit flush request strobe |
| tx_en_i | input | 1 | Transmitter enable |
| rx_en_i | input | 1 | Receiver enable |
| wake_en_i | input | 1 | Wakeup-from-stop enable |
| wake_sel_i | input | SW | Wakeup source select |
| wake_evt_i | input | NUM_WAKE | Wakeup event lines |
| wake_clr_i | input | 1 | Wakeup flag clear strobe |
| irq_mask_i | input | 5 | Per-flag interrupt enables |
| tx_thr_flag_o | output | 1 | Transmit threshold reached |
| rx_thr_flag_o | output | 1 | Receive threshold reached |
| rx_full_flag_o | output | 1 | Receive FIFO and holding register full |
| tx_empty_flag_o | output | 1 | Transmit FIFO empty |
| wake_flag_o | output | 1 | Wakeup event latched |
| tx_en_ack_o | output | 1 | Transmit enable taken into account |
| rx_en_ack_o | output | 1 | Receive enable taken into account |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The five flags are due one clock edge after the input that causes them. An acknowledge is due two edges after its enable changes. The interrupt is due one edge after a flag changes, which is two edges after the stimulus, or one edge after a mask change. Each check goes into the scoreboard with a due cycle counted from the edge at which the stimulus is sampled, and it is compared on the falling edge of that cycle. Strobes are held for exactly one cycle, and the inputs are left stable for at least three cycles before the next step, so every sample falls inside a settled window.

// File: rtl/uff_pkg.sv
package uff_pkg;

  localparam int NUM_FLAGS = 5;

  typedef enum int {
    F_TXTHR   = 0,
    F_RXTHR   = 1,
    F_RXFULL  = 2,
    F_TXEMPTY = 3,
    F_WAKE    = 4
  } flag_idx_e;

  // Threshold as a number of eighths of the FIFO depth; 0 for reserved codes.
  function automatic int thr_eighths(input logic [2:0] code);
    int n;
    case (code)
      3'd0:    n = 1;
      3'd1:    n = 2;
      3'd2:    n = 4;
      3'd3:    n = 6;
      3'd4:    n = 7;
      3'd5:    n = 8;
      default: n = 0;
    endcase
    return n;
  endfunction

  function automatic logic thr_valid(input logic [2:0] code);
    return (code <= 3'd5);
  endfunction

endpackage

// File: rtl/uff_thresh.sv
module uff_thresh #(
  parameter int DEPTH      = 8,
  parameter int LW         = $clog2(DEPTH + 1),
  parameter bit COUNT_FREE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] level_i,
  input  logic [2:0]    code_i,
  output logic          flag_o
);
  localparam int MW = LW + 1;

  logic [MW-1:0] metric;
  logic [MW-1:0] need;
  logic          hit;

  generate
    if (COUNT_FREE) begin : g_free
      assign metric = MW'(DEPTH) - MW'(level_i);
    end else begin : g_fill
      assign metric = MW'(level_i);
    end
  endgenerate

  always_comb begin
    need = MW'((DEPTH * uff_pkg::thr_eighths(code_i)) / 8);
    hit  = uff_pkg::thr_valid(code_i) && (metric >= need);
  end

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= hit;
  end

  // R4: a reserved code never yields a set flag
  a_r4_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(code_i) > 3'd5) |-> !flag_o);

endmodule

// File: rtl/uff_ack_sync.sv
module uff_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic ack_o
);
  logic chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= en_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign ack_o = chain[STAGES-1];

endmodule

// File: rtl/uff_wake.sv
module uff_wake #(
  parameter int NUM_SRC = 4,
  parameter int SW      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic [SW-1:0]      sel_i,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               clr_i,
  output logic               flag_o
);
  logic hit;

  assign hit = evt_i[sel_i];

  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (!en_i) flag_o <= 1'b0;
    else if (hit)   flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R10: disabled wakeup keeps the flag low
  a_r10_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !$past(en_i) |-> !flag_o);

  // R9: a selected event while enabled always leaves the flag set
  a_r9_event_sets: assert property (@(posedge clk) disable iff (rst)
    $past(en_i && evt_i[sel_i]) |-> flag_o);

endmodule

// File: rtl/uart_fifo_flags.sv
module uart_fifo_flags #(
  parameter int DEPTH       = 8,
  parameter int NUM_WAKE    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int LW          = $clog2(DEPTH + 1),
  parameter int SW          = $clog2(NUM_WAKE)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LW-1:0]       tx_level_i,
  input  logic [LW-1:0]       rx_level_i,
  input  logic                rx_hold_full_i,
  input  logic [2:0]          tx_thr_code_i,
  input  logic [2:0]          rx_thr_code_i,
  input  logic                tx_push_i,
  input  logic                tx_flush_req_i,
  input  logic                tx_en_i,
  input  logic                rx_en_i,
  input  logic                wake_en_i,
  input  logic [SW-1:0]       wake_sel_i,
  input  logic [NUM_WAKE-1:0] wake_evt_i,
  input  logic                wake_clr_i,
  input  logic [4:0]          irq_mask_i,
  output logic                tx_thr_flag_o,
  output logic                rx_thr_flag_o,
  output logic                rx_full_flag_o,
  output logic                tx_empty_flag_o,
  output logic                wake_flag_o,
  output logic                tx_en_ack_o,
  output logic                rx_en_ack_o,
  output logic                irq_o
);
  import uff_pkg::*;

  logic [NUM_FLAGS-1:0] flags;

  uff_thresh #(.DEPTH(DEPTH), .LW(LW), .COUNT_FREE(1'b1)) u_tx_thr (
    .clk(clk), .rst(rst), .level_i(tx_level_i), .code_i(tx_thr_code_i),
    .flag_o(tx_thr_flag_o));

  uff_thresh #(.DEPTH(DEPTH), .LW(LW), .COUNT_FREE(1'b0)) u_rx_thr (
    .clk(clk), .rst(rst), .level_i(rx_level_i), .code_i(rx_thr_code_i),
    .flag_o(rx_thr_flag_o));

  uff_ack_sync #(.STAGES(SYNC_STAGES)) u_tx_ack (
    .clk(clk), .rst(rst), .en_i(tx_en_i), .ack_o(tx_en_ack_o));

  uff_ack_sync #(.STAGES(SYNC_STAGES)) u_rx_ack (
    .clk(clk), .rst(rst), .en_i(rx_en_i), .ack_o(rx_en_ack_o));

  uff_wake #(.NUM_SRC(NUM_WAKE), .SW(SW)) u_wake (
    .clk(clk), .rst(rst), .en_i(wake_en_i), .sel_i(wake_sel_i),
    .evt_i(wake_evt_i), .clr_i(wake_clr_i), .flag_o(wake_flag_o));

  // Receive full: FIFO at depth and holding register occupied
  always_ff @(posedge clk) begin
    if (rst) rx_full_flag_o <= 1'b0;
    else     rx_full_flag_o <= (rx_level_i == LW'(DEPTH)) && rx_hold_full_i;
  end

  // Transmit empty: flush wins, push clears, empty level sets
  always_ff @(posedge clk) begin
    if (rst)                     tx_empty_flag_o <= 1'b1;
    else if (tx_flush_req_i)     tx_empty_flag_o <= 1'b1;
    else if (tx_push_i)          tx_empty_flag_o <= 1'b0;
    else if (tx_level_i == '0)   tx_empty_flag_o <= 1'b1;
  end

  always_comb begin
    flags            = '0;
    flags[F_TXTHR]   = tx_thr_flag_o;
    flags[F_RXTHR]   = rx_thr_flag_o;
    flags[F_RXFULL]  = rx_full_flag_o;
    flags[F_TXEMPTY] = tx_empty_flag_o;
    flags[F_WAKE]    = wake_flag_o;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(flags & irq_mask_i);
  end

  // R5: full flag only with an occupied holding register
  a_r5_full_needs_hold: assert property (@(posedge clk) disable iff (rst)
    rx_full_flag_o |-> $past(rx_hold_full_i));

  // R7: flush request always leaves the empty flag set
  a_r7_flush_sets: assert property (@(posedge clk) disable iff (rst)
    $past(tx_flush_req_i) |-> tx_empty_flag_o);

  // R6: a lone push clears the empty flag
  a_r6_push_clears: assert property (@(posedge clk) disable iff (rst)
    $past(tx_push_i && !tx_flush_req_i) |-> !tx_empty_flag_o);

  // R11: interrupt only from an enabled flag of the previous cycle
  a_r11_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(flags & irq_mask_i)));

  generate
    if (SYNC_STAGES == 2) begin : g_ack_chk
      // R8: acknowledge equals the enable of two cycles earlier
      a_r8_ack_delay: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (tx_en_ack_o == $past(tx_en_i, 2)));
    end
  endgenerate

endmodule

// File: tb/uart_fifo_flags_tb_top.sv
module uart_fifo_flags_tb_top;

  localparam int DEPTH = 8;
  localparam int LW    = 4;

  localparam int S_TXT = 0, S_RXT = 1, S_RXF = 2, S_TXE = 3, S_WK = 4,
                 S_TXA = 5, S_RXA = 6, S_IRQ = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LW-1:0] tx_level = '0, rx_level = '0;
  logic rx_hold = 1'b0;
  logic [2:0] tx_code = 3'd6, rx_code = 3'd6;
  logic push = 1'b0, flush = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
  logic wake_en = 1'b0, wake_clr = 1'b0;
  logic [1:0] wake_sel = '0;
  logic [3:0] wake_evt = '0;
  logic [4:0] mask = '0;
  logic txt, rxt, rxf, txe, wk, txa, rxa, irq;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct {
    int    due;
    int    sig;
    int    exp;
    string req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  uart_fifo_flags #(.DEPTH(DEPTH), .NUM_WAKE(4), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .tx_level_i(tx_level), .rx_level_i(rx_level),
    .rx_hold_full_i(rx_hold), .tx_thr_code_i(tx_code), .rx_thr_code_i(rx_code),
    .tx_push_i(push), .tx_flush_req_i(flush), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .wake_en_i(wake_en), .wake_sel_i(wake_sel), .wake_evt_i(wake_evt),
    .wake_clr_i(wake_clr), .irq_mask_i(mask),
    .tx_thr_flag_o(txt), .rx_thr_flag_o(rxt), .rx_full_flag_o(rxf),
    .tx_empty_flag_o(txe), .wake_flag_o(wk), .tx_en_ack_o(txa),
    .rx_en_ack_o(rxa), .irq_o(irq));

  function automatic int actual(int sig);
    case (sig)
      S_TXT:   return int'(txt);
      S_RXT:   return int'(rxt);
      S_RXF:   return int'(rxf);
      S_TXE:   return int'(txe);
      S_WK:    return int'(wk);
      S_TXA:   return int'(txa);
      S_RXA:   return int'(rxa);
      default: return int'(irq);
    endcase
  endfunction

  task automatic chk(int sig, int exp, string req);
    int act;
    act = actual(sig);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sig %0d cycle %0d actual %0d expected %0d", req, sig, cyc, act, exp);
    end
  endtask

  // driver side: expected value due dly edges after the current cycle
  task automatic expect_in(int dly, int sig, int exp, string req);
    exp_t e;
    e.due = cyc + dly;
    e.sig = sig;
    e.exp = exp;
    e.req = req;
    sb.push_back(e);
  endtask

  // monitor: compare every item due this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        chk(sb[i].sig, sb[i].exp, sb[i].req);
        sb.delete(i);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d actual 0 expected 1", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    step(4);
    // R1: reset values
    chk(S_TXT, 0, "R1"); chk(S_RXF, 0, "R1"); chk(S_TXE, 1, "R1");
    chk(S_WK, 0, "R1"); chk(S_TXA, 0, "R1"); chk(S_IRQ, 0, "R1");
    rst = 1'b0;
    chk(S_TXE, 1, "R1"); chk(S_RXT, 0, "R1");
    step(3);

    // R2: transmit threshold on free slots
    tx_code = 3'd2; tx_level = 4'd4; expect_in(1, S_TXT, 1, "R2"); step(3);
    tx_level = 4'd5;                  expect_in(1, S_TXT, 0, "R2"); step(3);
    tx_code = 3'd5; tx_level = 4'd0; expect_in(1, S_TXT, 1, "R2"); step(3);
    tx_code = 3'd7;                   expect_in(1, S_TXT, 0, "R4"); step(3);

    // R3: receive threshold on filled slots
    rx_code = 3'd3; rx_level = 4'd5; expect_in(1, S_RXT, 0, "R3"); step(3);
    rx_level = 4'd6;                  expect_in(1, S_RXT, 1, "R3"); step(3);
    rx_code = 3'd6;                   expect_in(1, S_RXT, 0, "R4"); step(3);

    // R5: full needs depth plus holding register
    rx_level = 4'd8; rx_hold = 1'b0; expect_in(1, S_RXF, 0, "R5"); step(3);
    rx_hold = 1'b1;                   expect_in(1, S_RXF, 1, "R5"); step(3);
    rx_level = 4'd7;                  expect_in(1, S_RXF, 0, "R5"); step(3);

    // R6 / R7: transmit empty
    push = 1'b1; expect_in(1, S_TXE, 0, "R6");
    step(1); push = 1'b0; tx_level = 4'd1; expect_in(2, S_TXE, 0, "R6"); step(3);
    flush = 1'b1; expect_in(1, S_TXE, 1, "R7");
    step(1); flush = 1'b0; expect_in(2, S_TXE, 1, "R7"); step(3);
    push = 1'b1; flush = 1'b1; expect_in(1, S_TXE, 1, "R7");
    step(1); push = 1'b0; flush = 1'b0; step(3);
    push = 1'b1; expect_in(1, S_TXE, 0, "R6");
    step(1); push = 1'b0; step(3);

    // R8: acknowledges after two cycles
    tx_en = 1'b1; expect_in(1, S_TXA, 0, "R8"); expect_in(2, S_TXA, 1, "R8"); step(3);
    rx_en = 1'b1; expect_in(1, S_RXA, 0, "R8"); expect_in(2, S_RXA, 1, "R8"); step(3);
    tx_en = 1'b0; expect_in(1, S_TXA, 1, "R8"); expect_in(2, S_TXA, 0, "R8"); step(3);

    // R9: wakeup set and clear
    wake_en = 1'b1; wake_sel = 2'd2;
    wake_evt = 4'b0010; expect_in(1, S_WK, 0, "R9");
    step(1); wake_evt = '0; step(3);
    wake_evt = 4'b0100; expect_in(1, S_WK, 1, "R9");
    step(1); wake_evt = '0; expect_in(2, S_WK, 1, "R9"); step(3);
    wake_clr = 1'b1; expect_in(1, S_WK, 0, "R9");
    step(1); wake_clr = 1'b0; step(3);
    wake_evt = 4'b0100; wake_clr = 1'b1; expect_in(1, S_WK, 1, "R9");
    step(1); wake_evt = '0; wake_clr = 1'b0; step(3);

    // R10: disabled wakeup
    wake_en = 1'b0; expect_in(1, S_WK, 0, "R10"); step(3);
    wake_evt = 4'b0100; expect_in(1, S_WK, 0, "R10");
    step(1); wake_evt = '0; step(3);

    // R11: interrupt masking (all flags now low)
    mask = 5'b11111; expect_in(1, S_IRQ, 0, "R11"); step(3);
    mask = 5'b01000; flush = 1'b1;
    expect_in(1, S_TXE, 1, "R7"); expect_in(2, S_IRQ, 1, "R11");
    step(1); flush = 1'b0; step(3);
    mask = 5'b10111; expect_in(1, S_IRQ, 0, "R11"); step(3);
    mask = 5'b00100; rx_level = 4'd8;
    expect_in(1, S_RXF, 1, "R5"); expect_in(2, S_IRQ, 1, "R11"); step(3);
    mask = 5'b00000; expect_in(1, S_IRQ, 0, "R11"); step(3);

    step(2);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d items actual %0d expected 0", sb.size(), sb.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule